// File: doc/BRIEF.md
# Hierarchical Power Domain Controller

This block decides the power state of five domains of a chip: three stacked switchable peripheral domains (index 0 is the lowest, index 2 the highest), one domain that holds the core controllers, and one always-on backup domain. Its inputs are the current sleep-mode code, one "peripheral needed" request for each switchable domain, and one configuration bit for each switchable domain. That bit chooses whether an unneeded domain is kept in retention or fully switched off while the chip sleeps.

For every domain the block drives a power-switch enable and waits for an acknowledge from that switch. It then reports the domain as on, in retention, or off. The stacked domains follow a monotone rule: when a domain must be powered, every domain below it is powered as well. Power-up moves from the lowest domain upward, and power-down moves from the highest domain downward. As a result no switchable domain is ever powered while a domain beneath it is unpowered. The core domain has only two states, on and off. The backup domain stays on in every mode except the off mode.

Top module: `pwr_domain_ctrl`

## Requirements
- R1: Sleep-mode code 0 (active), code 1 (idle) and the unused codes 5, 6 and 7 drive all five domains to the on state, whatever the requests are.
- R2: In code 2 (standby) and code 3 (backup), switchable domain i is targeted on exactly when periph_req[i] or any periph_req bit above i is set.
- R3: In standby or backup mode, a switchable domain that is not targeted on settles in retention when ret_cfg[i] is 1 and in off when ret_cfg[i] is 0.
- R4: The core domain (index 3) is on in active, idle and standby modes and off in backup and off modes. It never reports retention.
- R5: The backup domain (index 4) is on in every mode except code 4 (off). In code 4 every domain settles in off.
- R6: Switch enable sw_en[i] for i = 1 or 2 rises only after a clock edge at which sw_en[i-1] and sw_ack[i-1] were both high.
- R7: Switch enable sw_en[i] for i = 0 or 1 falls only after a clock edge at which sw_en[i+1] and sw_ack[i+1] were both low.
- R8: dom_state bits [2k+1:2k] give the state of domain k, encoded off=0, retention=1, on=2. After an edge at which sw_en[k] and sw_ack[k] are both high the field becomes on. After an edge at which both are low it becomes the domain's low state (R3, R4, R5). When the two disagree the field holds its value.
- R9: During reset every sw_en bit is 1 and every domain reports on. At the first clock edge after reset release, neither output changes.
- R10: Once the controller is armed, an sw_en bit changes at the first clock edge at which its target and its ordering condition allow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_mode | input | 3 | Sleep-mode code (0 active, 1 idle, 2 standby, 3 backup, 4 off) |
| periph_req | input | N_SW | Per switchable domain: a peripheral in it is needed |
| ret_cfg | input | N_SW | Per switchable domain: 1 keeps retention when unneeded, 0 switches off |
| sw_ack | input | N_SW+2 | Acknowledge from each domain's power switch |
| sw_en | output | N_SW+2 | Power-switch enable for each domain |
| dom_state | output | 2*(N_SW+2) | Two-bit state field for each domain |

## Verification
The bench first walks the controller through every sleep mode while all requests are clear. This shows that active, idle and an unused code all give full power, and that the off mode empties every domain. Standby and backup are then each run with a single request at different heights of the stack (only the lowest, only the middle, only the top). Together these show that the closure reaches downward but never upward. The retention bits are set differently from one run to the next, which separates retention from off and shows that the core domain ignores its configuration. Acknowledges return two cycles after each enable, so the ordering gaps appear in every transition and the bench sees each step of both power-up and power-down.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  typedef enum logic [1:0] {
    PS_OFF = 2'd0,
    PS_RET = 2'd1,
    PS_ON  = 2'd2
  } pstate_e;

  localparam logic [2:0] MODE_ACTIVE  = 3'd0;
  localparam logic [2:0] MODE_IDLE    = 3'd1;
  localparam logic [2:0] MODE_STANDBY = 3'd2;
  localparam logic [2:0] MODE_BACKUP  = 3'd3;
  localparam logic [2:0] MODE_OFF     = 3'd4;

  // Low-power modes in which switchable domains follow their requests (R2, R3)
  function automatic logic mode_follows_req(input logic [2:0] m);
    return (m == MODE_STANDBY) || (m == MODE_BACKUP);
  endfunction

  // Core-controller domain target (R4)
  function automatic logic core_target(input logic [2:0] m);
    return !((m == MODE_BACKUP) || (m == MODE_OFF));
  endfunction

  // Backup domain target (R5)
  function automatic logic bkp_target(input logic [2:0] m);
    return m != MODE_OFF;
  endfunction

  // Switchable domain target, given its closure of requests (R1, R2)
  function automatic logic sw_target(input logic [2:0] m, input logic closure_on);
    if (m == MODE_OFF)        return 1'b0;
    if (mode_follows_req(m))  return closure_on;
    return 1'b1;
  endfunction

endpackage

// File: rtl/pdc_target.sv
module pdc_target
  import pdc_pkg::*;
#(
  parameter int N_SW = 3,
  localparam int NDOM = N_SW + 2
) (
  input  logic [2:0]      sleep_mode,
  input  logic [N_SW-1:0] periph_req,
  input  logic [N_SW-1:0] ret_cfg,
  output logic [NDOM-1:0] tgt_on,
  output logic [NDOM-1:0] low_ret
);

  logic [N_SW-1:0] closure_on;
  logic            lp_mode;

  assign lp_mode = mode_follows_req(sleep_mode);

  // Monotone closure: a domain is needed if it or any higher domain is needed (R2)
  for (genvar i = 0; i < N_SW; i++) begin : g_sw
    assign closure_on[i] = |periph_req[N_SW-1:i];
    assign tgt_on[i]     = sw_target(sleep_mode, closure_on[i]);
    // Retention only when the mode lets requests decide (R3)
    assign low_ret[i]    = lp_mode & ret_cfg[i];
  end

  assign tgt_on[N_SW]      = core_target(sleep_mode);
  assign tgt_on[N_SW+1]    = bkp_target(sleep_mode);
  assign low_ret[N_SW]     = 1'b0;  // core never retains (R4)
  assign low_ret[N_SW+1]   = 1'b0;

endmodule

// File: rtl/pdc_chain.sv
module pdc_chain #(
  parameter int N_SW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            armed,
  input  logic [N_SW-1:0] tgt_on,
  input  logic [N_SW-1:0] sw_ack,
  output logic [N_SW-1:0] en_q
);

  for (genvar i = 0; i < N_SW; i++) begin : g_dom
    logic up_ok;   // domain below is enabled and acknowledged (R6)
    logic dn_ok;   // domain above is released and acknowledged off (R7)
    logic en_r;

    if (i == 0) begin : g_bottom
      assign up_ok = 1'b1;
    end else begin : g_upper
      assign up_ok = en_q[i-1] & sw_ack[i-1];
    end

    if (i == N_SW - 1) begin : g_top
      assign dn_ok = 1'b1;
    end else begin : g_lower
      assign dn_ok = ~en_q[i+1] & ~sw_ack[i+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_r <= 1'b1;
      end else if (armed) begin
        if (en_r) begin
          if (!tgt_on[i] && dn_ok) en_r <= 1'b0;
        end else if (tgt_on[i] && up_ok) begin
          en_r <= 1'b1;
        end
      end
    end

    assign en_q[i] = en_r;
  end

endmodule

// File: rtl/pdc_tracker.sv
module pdc_tracker
  import pdc_pkg::*;
#(
  parameter int NDOM = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic [NDOM-1:0]   sw_en,
  input  logic [NDOM-1:0]   sw_ack,
  input  logic [NDOM-1:0]   low_ret,
  output logic [2*NDOM-1:0] state
);

  for (genvar k = 0; k < NDOM; k++) begin : g_dom
    pstate_e st_r;
    logic    settled_on;
    logic    settled_low;

    assign settled_on  = sw_en[k] & sw_ack[k];
    assign settled_low = ~sw_en[k] & ~sw_ack[k];

    // R8: update only when switch and enable agree
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r <= PS_ON;
      end else if (armed) begin
        if (settled_on)       st_r <= PS_ON;
        else if (settled_low) st_r <= low_ret[k] ? PS_RET : PS_OFF;
      end
    end

    assign state[2*k +: 2] = st_r;
  end

endmodule

// File: rtl/pwr_domain_ctrl.sv
module pwr_domain_ctrl
  import pdc_pkg::*;
#(
  parameter int N_SW = 3,
  localparam int NDOM = N_SW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        sleep_mode,
  input  logic [N_SW-1:0]   periph_req,
  input  logic [N_SW-1:0]   ret_cfg,
  input  logic [NDOM-1:0]   sw_ack,
  output logic [NDOM-1:0]   sw_en,
  output logic [2*NDOM-1:0] dom_state
);

  logic            eval_armed;   // low for the first edge after reset (R9)
  logic [NDOM-1:0] tgt_on;
  logic [NDOM-1:0] low_ret;
  logic [N_SW-1:0] chain_en;
  logic [1:0]      side_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eval_armed <= 1'b0;
    else        eval_armed <= 1'b1;
  end

  pdc_target #(.N_SW(N_SW)) u_target (
    .sleep_mode (sleep_mode),
    .periph_req (periph_req),
    .ret_cfg    (ret_cfg),
    .tgt_on     (tgt_on),
    .low_ret    (low_ret)
  );

  pdc_chain #(.N_SW(N_SW)) u_chain (
    .clk    (clk),
    .rst_n  (rst_n),
    .armed  (eval_armed),
    .tgt_on (tgt_on[N_SW-1:0]),
    .sw_ack (sw_ack[N_SW-1:0]),
    .en_q   (chain_en)
  );

  // Core and backup domains are not stacked: enables follow targets (R4, R5)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          side_en <= 2'b11;
    else if (eval_armed) side_en <= tgt_on[NDOM-1:N_SW];
  end

  assign sw_en = {side_en, chain_en};

  pdc_tracker #(.NDOM(NDOM)) u_tracker (
    .clk     (clk),
    .rst_n   (rst_n),
    .armed   (eval_armed),
    .sw_en   (sw_en),
    .sw_ack  (sw_ack),
    .low_ret (low_ret),
    .state   (dom_state)
  );

endmodule

// File: rtl/pdc_checker.sv
module pdc_checker #(
  parameter int N_SW = 3,
  localparam int NDOM = N_SW + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eval_armed,
  input logic [NDOM-1:0]   sw_en,
  input logic [NDOM-1:0]   sw_ack,
  input logic [2*NDOM-1:0] dom_state
);

  // R6: an upper enable rises only above a powered, acknowledged lower domain
  for (genvar i = 1; i < N_SW; i++) begin : g_up
    a_r6_up_order: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_en[i]) |-> $past(sw_en[i-1] && sw_ack[i-1]));
  end

  // R7: a lower enable falls only once the domain above is fully released
  for (genvar i = 0; i < N_SW - 1; i++) begin : g_dn
    a_r7_down_order: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_en[i]) |-> $past(!sw_en[i+1] && !sw_ack[i+1]));
  end

  // R8: a field turns on only after enable and acknowledge were both high
  for (genvar k = 0; k < NDOM; k++) begin : g_on
    a_r8_on_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (dom_state[2*k +: 2] == 2'd2 && $past(dom_state[2*k +: 2]) != 2'd2)
        |-> $past(sw_en[k] && sw_ack[k]));
  end

  // R4: the core domain never reports retention
  a_r4_core_no_ret: assert property (@(posedge clk) disable iff (!rst_n)
    dom_state[2*N_SW +: 2] != 2'd1);

  // R5: the backup domain never reports retention
  a_r5_bkp_no_ret: assert property (@(posedge clk) disable iff (!rst_n)
    dom_state[2*(N_SW+1) +: 2] != 2'd1);

  // R9: nothing moves at the first edge after reset release
  a_r9_first_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_armed |=> ($stable(dom_state) && $stable(sw_en)));

endmodule

bind pwr_domain_ctrl pdc_checker #(.N_SW(N_SW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .eval_armed (eval_armed),
  .sw_en      (sw_en),
  .sw_ack     (sw_ack),
  .dom_state  (dom_state)
);

// File: tb/pwr_domain_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_domain_ctrl_tb_top;
  localparam int N_SW = 3;
  localparam int NDOM = N_SW + 2;
  localparam logic [1:0] S_OFF = 2'd0, S_RET = 2'd1, S_ON = 2'd2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic [2:0]        sleep_mode;
  logic [N_SW-1:0]   periph_req, ret_cfg;
  logic [NDOM-1:0]   sw_ack, sw_en;
  logic [2*NDOM-1:0] dom_state;

  pwr_domain_ctrl #(.N_SW(N_SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_mode(sleep_mode), .periph_req(periph_req),
    .ret_cfg(ret_cfg), .sw_ack(sw_ack), .sw_en(sw_en), .dom_state(dom_state)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  int m_en[NDOM];
  int m_st[NDOM];
  int m_armed;
  logic [NDOM-1:0] ack_d1, prev_en, prev_ack;

  // Target from the requirements, written as a plain decision list
  function automatic int want_on(int k);
    int md = int'(sleep_mode);
    bit lp = (md == 2) || (md == 3);
    if (k == NDOM - 1) return (md != 4) ? 1 : 0;          // R5
    if (k == NDOM - 2) return (md == 3 || md == 4) ? 0 : 1; // R4
    if (md == 4) return 0;
    if (!lp) return 1;                                      // R1
    for (int j = k; j < N_SW; j++) if (periph_req[j]) return 1; // R2
    return 0;
  endfunction

  task automatic model_next();
    int nen[NDOM];
    int nst[NDOM];
    if (m_armed == 0) begin m_armed = 1; return; end
    for (int k = 0; k < NDOM; k++) begin
      int tg = want_on(k);
      int low;
      if (k < N_SW) begin
        int below = (k == 0) ? 1 : ((m_en[k-1] == 1 && sw_ack[k-1]) ? 1 : 0);
        int above = (k == N_SW-1) ? 1 : ((m_en[k+1] == 0 && !sw_ack[k+1]) ? 1 : 0);
        if (m_en[k] == 1) nen[k] = (tg == 1 || above == 0) ? 1 : 0;
        else              nen[k] = (tg == 1 && below == 1) ? 1 : 0;
      end else begin
        nen[k] = tg;
      end
      low = (k < N_SW && (sleep_mode == 3'd2 || sleep_mode == 3'd3) && ret_cfg[k]) ? 1 : 0;
      if (m_en[k] == 1 && sw_ack[k])       nst[k] = 2;
      else if (m_en[k] == 0 && !sw_ack[k]) nst[k] = low;
      else                                 nst[k] = m_st[k];
    end
    for (int k = 0; k < NDOM; k++) begin m_en[k] = nen[k]; m_st[k] = nst[k]; end
  endtask

  task automatic compare();
    logic [NDOM-1:0]   e_en;
    logic [2*NDOM-1:0] e_st;
    for (int k = 0; k < NDOM; k++) begin
      e_en[k] = (m_en[k] == 1);
      e_st[2*k +: 2] = 2'(m_st[k]);
    end
    n_run++;
    if (sw_en !== e_en) begin
      n_fail++;
      $display("FAIL R10 cycle %0d sw_en got %b exp %b", cyc, sw_en, e_en);
    end
    n_run++;
    if (dom_state !== e_st) begin
      n_fail++;
      $display("FAIL R8 cycle %0d dom_state got %h exp %h", cyc, dom_state, e_st);
    end
    for (int i = 1; i < N_SW; i++) if (sw_en[i] && !prev_en[i]) begin
      n_run++;
      if (!(prev_en[i-1] && prev_ack[i-1])) begin
        n_fail++;
        $display("FAIL R6 cycle %0d dom %0d below en/ack got %b%b exp 11", cyc, i,
                 prev_en[i-1], prev_ack[i-1]);
      end
    end
    for (int i = 0; i < N_SW - 1; i++) if (!sw_en[i] && prev_en[i]) begin
      n_run++;
      if (prev_en[i+1] || prev_ack[i+1]) begin
        n_fail++;
        $display("FAIL R7 cycle %0d dom %0d above en/ack got %b%b exp 00", cyc, i,
                 prev_en[i+1], prev_ack[i+1]);
      end
    end
  endtask

  task automatic run(int n);
    repeat (n) begin
      model_next();
      @(negedge clk);
      cyc++;
      compare();
      sw_ack   = ack_d1;   // switches answer two cycles after the enable
      ack_d1   = sw_en;
      prev_en  = sw_en;
      prev_ack = sw_ack;
    end
  endtask

  task automatic expect_states(string tag, logic [2*NDOM-1:0] exp_st);
    n_run++;
    if (dom_state !== exp_st) begin
      n_fail++;
      $display("FAIL %s dom_state got %h exp %h", tag, dom_state, exp_st);
    end
  endtask

  task automatic expect_en(string tag, logic [NDOM-1:0] exp_en);
    n_run++;
    if (sw_en !== exp_en) begin
      n_fail++;
      $display("FAIL %s sw_en got %b exp %b", tag, sw_en, exp_en);
    end
  endtask

  initial begin
    rst_n = 1'b0; sleep_mode = 3'd0; periph_req = '0; ret_cfg = '0;
    sw_ack = '1; ack_d1 = '1; prev_en = '1; prev_ack = '1;
    m_armed = 0;
    for (int k = 0; k < NDOM; k++) begin m_en[k] = 1; m_st[k] = 2; end
    repeat (3) @(negedge clk);
    expect_en("R9 reset", 5'b11111);
    expect_states("R9 reset", {S_ON, S_ON, S_ON, S_ON, S_ON});
    rst_n = 1'b1;
    sleep_mode = 3'd4;                 // off mode at once
    run(1);
    expect_en("R9 first edge hold", 5'b11111);
    expect_states("R9 first edge hold", {S_ON, S_ON, S_ON, S_ON, S_ON});
    run(30);
    expect_states("R5 off mode", {S_OFF, S_OFF, S_OFF, S_OFF, S_OFF});
    expect_en("R5 off mode", 5'b00000);

    sleep_mode = 3'd0; periph_req = 3'b000;
    run(30);
    expect_states("R1 active", {S_ON, S_ON, S_ON, S_ON, S_ON});

    sleep_mode = 3'd2; periph_req = 3'b010; ret_cfg = 3'b100;
    run(30);
    expect_states("R2 R3 R4 standby mid req", {S_ON, S_ON, S_RET, S_ON, S_ON});

    sleep_mode = 3'd3; periph_req = 3'b000; ret_cfg = 3'b011;
    run(30);
    expect_states("R3 R4 R5 backup no req", {S_ON, S_OFF, S_OFF, S_RET, S_RET});

    periph_req = 3'b100;
    run(30);
    expect_states("R2 R4 backup top req", {S_ON, S_OFF, S_ON, S_ON, S_ON});

    sleep_mode = 3'd1; periph_req = 3'b000;
    run(30);
    expect_states("R1 idle", {S_ON, S_ON, S_ON, S_ON, S_ON});

    sleep_mode = 3'd2; ret_cfg = 3'b000;
    run(30);
    expect_states("R3 standby all off", {S_ON, S_ON, S_OFF, S_OFF, S_OFF});

    sleep_mode = 3'd6;
    run(30);
    expect_states("R1 unused code", {S_ON, S_ON, S_ON, S_ON, S_ON});

    sleep_mode = 3'd2; periph_req = 3'b001; ret_cfg = 3'b110;
    run(30);
    expect_states("R2 R3 standby low req", {S_ON, S_ON, S_RET, S_RET, S_ON});

    sleep_mode = 3'd4;
    run(30);
    expect_states("R5 off after standby", {S_OFF, S_OFF, S_OFF, S_OFF, S_OFF});

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog expired at cycle %0d", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule